// File: doc/BRIEF.md
# Disk Sector Byte Serializer/Deserializer with CRC-16

This block sits between the bit-level disk path and the byte-wide sector logic. In the read direction it takes recovered NRZ bits, one per `bit_en` strobe, and assembles them into bytes. Each bit passes through a CRC-16 checker. Finished bytes are copied into a holding register, so the next byte can shift in while the consumer fetches the current one. At the end of the field the remainder is tested and any mismatch is latched.

In the write direction the producer hands bytes into a one-byte buffer. The block moves each byte into a shift register and sends it out MSB first, one bit per strobe, through the same CRC unit. Once the producer marks the last byte and the data runs out, the output source switches to the CRC register. The 16 check bits go out high byte first, and then the block returns to idle.

A field begins with `field_go`. In the read direction this pulse is the sync-mark-found event. It presets the CRC and clears the flags. `mode_wr` is sampled on the same cycle and selects the direction.

Top module: `disk_serdes`

## Requirements
- R1: After reset `rd_ready`, `wr_ready`, `tx_active`, `tx_bit`, `crc_err` and `xfer_err` are all 0.
- R2: In write mode each loaded byte is emitted on `tx_bit` MSB first, one bit per `bit_en` strobe, with `tx_active` high. `tx_bit` holds the bit that the next strobe consumes.
- R3: After the last data byte, the 16 bits of CRC-16 (polynomial 0x1021, preset 0xFFFF, computed MSB first over the data) are emitted high bit first. `tx_active` then falls and the block goes idle.
- R4: Bits strobed before `field_go`, or after a field has ended, are ignored. They produce no `rd_ready`, and they do not affect the CRC of the next field.
- R5: In read mode every 8 strobed bits form one byte, first bit in bit 7. The byte appears on `rd_data` with `rd_ready`=1 in the cycle after the eighth strobe. `rd_take` clears `rd_ready`.
- R6: A held byte stays on `rd_data` while the next byte shifts in. If a byte completes while `rd_ready` is still 1 and not being taken, `xfer_err` is set and the new byte replaces the old one.
- R7: In read mode a `last_word` pulse ends the field. `crc_err` is set if the remainder over the data plus the two CRC bytes is nonzero, and stays 0 if the remainder is zero.
- R8: In write mode `xfer_err` is set in two cases: a strobe arrives with no byte to send and no last byte marked (underrun), or `wr_load` arrives while both the buffer and the shift register are full (overflow).
- R9: `field_go` clears `crc_err`, `xfer_err`, `rd_ready` and every pending byte.
- R10: `wr_ready` is 1 only in write mode when the byte buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wr | input | 1 | Direction for the next field, sampled with `field_go` (1 = write) |
| field_go | input | 1 | Start of field: sync mark found (read) or write start |
| last_word | input | 1 | Read: end of field, check CRC. Write: the last data byte has been loaded |
| bit_en | input | 1 | Bit-cell strobe, one per serial bit |
| rx_bit | input | 1 | Recovered NRZ read bit |
| rd_take | input | 1 | Consumer has fetched `rd_data` |
| rd_data | output | 8 | Holding register with the last assembled byte |
| rd_ready | output | 1 | Holding register has an unfetched byte |
| wr_load | input | 1 | Load `wr_byte` into the write buffer |
| wr_byte | input | 8 | Byte to write |
| wr_ready | output | 1 | Write buffer is empty |
| tx_bit | output | 1 | Serial write bit toward the encoder |
| tx_active | output | 1 | `tx_bit` carries data or CRC |
| crc_err | output | 1 | CRC mismatch latched at end of read field |
| xfer_err | output | 1 | Read overrun, write underrun or write overflow |

## Verification
The bound assertions check the cycle-level rules on every cycle:
- `field_go` clears the flags.
- `rd_take` empties the holding register.
- `rd_ready` and `crc_err` rise only after a bit strobe or an end-of-field pulse.
- `tx_bit` never moves between strobes.

Only the bench's scenarios can show that the serial order and the CRC values are right. The write side is swept over every single-byte value and over several multi-byte frames. The read side gets the same streams with the CRC computed in the bench, with and without a flipped bit. Underrun, overflow, overrun and ignored pre-field bits are each driven on purpose.

// File: rtl/serdes_pkg.sv
package serdes_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_WR   = 2'd2,
        ST_WCRC = 2'd3
    } serdes_state_e;

    localparam logic [15:0] CRC16_POLY = 16'h1021;
    localparam logic [15:0] CRC16_INIT = 16'hFFFF;

endpackage

// File: rtl/serdes_crc.sv
module serdes_crc #(
    parameter int          CRC_W = 16,
    parameter logic [CRC_W-1:0] POLY = 16'h1021,
    parameter logic [CRC_W-1:0] INIT = 16'hFFFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             preset,
    input  logic             step,
    input  logic             drain,
    input  logic             din,
    output logic [CRC_W-1:0] crc
);
    logic [CRC_W-1:0] crc_d, crc_q;
    logic             fb;

    always_comb begin
        fb    = drain ? 1'b0 : (crc_q[CRC_W-1] ^ din);
        crc_d = crc_q;
        if (preset)
            crc_d = INIT;
        else if (step)
            crc_d = {crc_q[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) crc_q <= INIT;
        else        crc_q <= crc_d;
    end

    assign crc = crc_q;
endmodule

// File: rtl/serdes_bitcnt.sv
module serdes_bitcnt #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)      cnt_d = '0;
        else if (inc) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/disk_serdes.sv
module disk_serdes
    import serdes_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int CRC_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_wr,
    input  logic              field_go,
    input  logic              last_word,
    input  logic              bit_en,
    input  logic              rx_bit,
    input  logic              rd_take,
    output logic [BYTE_W-1:0] rd_data,
    output logic              rd_ready,
    input  logic              wr_load,
    input  logic [BYTE_W-1:0] wr_byte,
    output logic              wr_ready,
    output logic              tx_bit,
    output logic              tx_active,
    output logic              crc_err,
    output logic              xfer_err
);
    localparam int CNT_W = $clog2(CRC_W) + 1;
    localparam logic [CNT_W-1:0] BYTE_LAST = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] CRC_LAST  = CNT_W'(CRC_W - 1);

    typedef struct packed {
        serdes_state_e     st;
        logic [BYTE_W-1:0] sipo;
        logic [BYTE_W-1:0] hold;
        logic [BYTE_W-1:0] wbuf;
        logic [BYTE_W-1:0] sh;
        logic              rd_full;
        logic              wr_full;
        logic              sh_full;
        logic              last_pend;
        logic              crc_err;
        logic              xfer_err;
    } regs_t;

    regs_t r_d, r_q;

    logic             cnt_clr, cnt_inc;
    logic [CNT_W-1:0] cnt_q;
    logic             crc_pre, crc_step, crc_drain, crc_din;
    logic [CRC_W-1:0] crc_q;
    logic [BYTE_W-1:0] rx_next;

    serdes_bitcnt #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .cnt   (cnt_q)
    );

    serdes_crc #(
        .CRC_W (CRC_W),
        .POLY  (CRC_W'(CRC16_POLY)),
        .INIT  (CRC_W'(CRC16_INIT))
    ) u_crc (
        .clk    (clk),
        .rst_n  (rst_n),
        .preset (crc_pre),
        .step   (crc_step),
        .drain  (crc_drain),
        .din    (crc_din),
        .crc    (crc_q)
    );

    always_comb begin
        r_d       = r_q;
        cnt_clr   = 1'b0;
        cnt_inc   = 1'b0;
        crc_pre   = 1'b0;
        crc_step  = 1'b0;
        crc_drain = 1'b0;
        crc_din   = 1'b0;
        rx_next   = {r_q.sipo[BYTE_W-2:0], rx_bit};

        if (field_go) begin
            crc_pre     = 1'b1;
            cnt_clr     = 1'b1;
            r_d.rd_full   = 1'b0;
            r_d.wr_full   = 1'b0;
            r_d.sh_full   = 1'b0;
            r_d.last_pend = 1'b0;
            r_d.crc_err   = 1'b0;
            r_d.xfer_err  = 1'b0;
            r_d.st        = mode_wr ? ST_WR : ST_RD;
        end else begin
            if (rd_take) r_d.rd_full = 1'b0;
            unique case (r_q.st)
                ST_RD: begin
                    if (bit_en) begin
                        crc_step = 1'b1;
                        crc_din  = rx_bit;
                        r_d.sipo = rx_next;
                        if (cnt_q == BYTE_LAST) begin
                            cnt_clr     = 1'b1;
                            r_d.hold    = rx_next;
                            r_d.rd_full = 1'b1;
                            if (r_q.rd_full && !rd_take) r_d.xfer_err = 1'b1;
                        end else begin
                            cnt_inc = 1'b1;
                        end
                    end
                    if (last_word) begin
                        r_d.crc_err = (crc_q != '0);
                        r_d.st      = ST_IDLE;
                    end
                end
                ST_WR: begin
                    // move buffer into the shift register when it is free
                    if (!r_q.sh_full && r_q.wr_full) begin
                        r_d.sh      = r_q.wbuf;
                        r_d.sh_full = 1'b1;
                        r_d.wr_full = 1'b0;
                    end
                    if (wr_load) begin
                        if (r_d.wr_full) begin
                            r_d.xfer_err = 1'b1;
                        end else begin
                            r_d.wbuf    = wr_byte;
                            r_d.wr_full = 1'b1;
                        end
                    end
                    if (last_word) r_d.last_pend = 1'b1;
                    if (bit_en) begin
                        if (r_q.sh_full) begin
                            crc_step = 1'b1;
                            crc_din  = r_q.sh[BYTE_W-1];
                            r_d.sh   = {r_q.sh[BYTE_W-2:0], 1'b0};
                            if (cnt_q == BYTE_LAST) begin
                                cnt_clr     = 1'b1;
                                r_d.sh_full = 1'b0;
                                if (!r_q.wr_full && !wr_load && r_q.last_pend)
                                    r_d.st = ST_WCRC;
                            end else begin
                                cnt_inc = 1'b1;
                            end
                        end else if (!r_q.last_pend) begin
                            r_d.xfer_err = 1'b1;
                        end
                    end
                    if (!r_q.sh_full && !r_q.wr_full && !wr_load && r_q.last_pend) begin
                        cnt_clr = 1'b1;
                        r_d.st  = ST_WCRC;
                    end
                end
                ST_WCRC: begin
                    if (bit_en) begin
                        crc_step  = 1'b1;
                        crc_drain = 1'b1;
                        if (cnt_q == CRC_LAST) begin
                            cnt_clr = 1'b1;
                            r_d.st  = ST_IDLE;
                        end else begin
                            cnt_inc = 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st        <= ST_IDLE;
            r_q.sipo      <= '0;
            r_q.hold      <= '0;
            r_q.wbuf      <= '0;
            r_q.sh        <= '0;
            r_q.rd_full   <= 1'b0;
            r_q.wr_full   <= 1'b0;
            r_q.sh_full   <= 1'b0;
            r_q.last_pend <= 1'b0;
            r_q.crc_err   <= 1'b0;
            r_q.xfer_err  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rd_data   = r_q.hold;
    assign rd_ready  = r_q.rd_full;
    assign wr_ready  = (r_q.st == ST_WR) && !r_q.wr_full;
    assign tx_active = (r_q.st == ST_WCRC) || ((r_q.st == ST_WR) && r_q.sh_full);
    assign tx_bit    = (r_q.st == ST_WCRC) ? crc_q[CRC_W-1] :
                       ((r_q.st == ST_WR) && r_q.sh_full) ? r_q.sh[BYTE_W-1] : 1'b0;
    assign crc_err   = r_q.crc_err;
    assign xfer_err  = r_q.xfer_err;
endmodule

// File: rtl/disk_serdes_chk.sv
module disk_serdes_chk (
    input logic clk,
    input logic rst_n,
    input logic field_go,
    input logic last_word,
    input logic bit_en,
    input logic rd_take,
    input logic rd_ready,
    input logic wr_ready,
    input logic tx_bit,
    input logic tx_active,
    input logic crc_err,
    input logic xfer_err
);
    assert_go_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        field_go |=> (!crc_err && !xfer_err && !rd_ready));

    assert_take_empties_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_take && !bit_en && !field_go) |=> !rd_ready);

    assert_byte_needs_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_ready) |-> $past(bit_en));

    assert_crc_err_at_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(crc_err) |-> $past(last_word));

    assert_tx_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_active && !bit_en && !field_go) |=> $stable(tx_bit));

    assert_modes_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready |-> !rd_ready);
endmodule

bind disk_serdes disk_serdes_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .field_go  (field_go),
    .last_word (last_word),
    .bit_en    (bit_en),
    .rd_take   (rd_take),
    .rd_ready  (rd_ready),
    .wr_ready  (wr_ready),
    .tx_bit    (tx_bit),
    .tx_active (tx_active),
    .crc_err   (crc_err),
    .xfer_err  (xfer_err)
);

// File: tb/disk_serdes_tb.sv
module disk_serdes_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_wr = 1'b0, field_go = 1'b0, last_word = 1'b0;
    logic       bit_en = 1'b0, rx_bit = 1'b0, rd_take = 1'b0;
    logic       wr_load = 1'b0;
    logic [7:0] wr_byte = 8'h00;
    logic [7:0] rd_data;
    logic       rd_ready, wr_ready, tx_bit, tx_active, crc_err, xfer_err;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [7:0] frm [0:5];
    logic       cap [0:47];

    always #4 clk = ~clk;

    disk_serdes u_dut (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .field_go(field_go),
        .last_word(last_word), .bit_en(bit_en), .rx_bit(rx_bit),
        .rd_take(rd_take), .rd_data(rd_data), .rd_ready(rd_ready),
        .wr_load(wr_load), .wr_byte(wr_byte), .wr_ready(wr_ready),
        .tx_bit(tx_bit), .tx_active(tx_active), .crc_err(crc_err),
        .xfer_err(xfer_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] crc_of(input int n);
        logic [15:0] c = 16'hFFFF;
        for (int i = 0; i < n; i++)
            for (int b = 7; b >= 0; b--) begin
                logic fb = c[15] ^ frm[i][b];
                c = {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
            end
        return c;
    endfunction

    task automatic go(input logic wr);
        @(negedge clk); mode_wr = wr; field_go = 1'b1;
        @(negedge clk); field_go = 1'b0;
    endtask

    task automatic pulse_last();
        @(negedge clk); last_word = 1'b1;
        @(negedge clk); last_word = 1'b0;
    endtask

    task automatic load(input logic [7:0] v);
        while (!wr_ready) @(negedge clk);
        wr_byte = v; wr_load = 1'b1;
        @(negedge clk); wr_load = 1'b0;
    endtask

    task automatic tx_one(output logic b);
        @(negedge clk); b = tx_bit; bit_en = 1'b1;
        @(negedge clk); bit_en = 1'b0;
    endtask

    task automatic rx_one(input logic v);
        @(negedge clk); rx_bit = v; bit_en = 1'b1;
        @(negedge clk); bit_en = 1'b0;
    endtask

    task automatic take();
        @(negedge clk); rd_take = 1'b1;
        @(negedge clk); rd_take = 1'b0;
    endtask

    // write n bytes of frm, compare serial output with data then CRC
    task automatic write_frame(input int n);
        logic [15:0] c;
        logic [7:0]  got;
        logic [15:0] gc;
        c = crc_of(n);
        go(1'b1);
        load(frm[0]);
        for (int j = 0; j < n; j++) begin
            if (j + 1 < n) load(frm[j+1]);
            else pulse_last();
            for (int b = 0; b < 8; b++) begin
                logic t;
                tx_one(t);
                cap[j*8+b] = t;
            end
        end
        for (int k = 0; k < 16; k++) begin
            logic t;
            tx_one(t);
            cap[n*8+k] = t;
        end
        for (int j = 0; j < n; j++) begin
            for (int b = 0; b < 8; b++) got[7-b] = cap[j*8+b];
            check(got == frm[j], "R2 tx data byte", got, frm[j]);
        end
        for (int k = 0; k < 16; k++) gc[15-k] = cap[n*8+k];
        check(gc == c, "R3 tx crc", gc, c);
        check(tx_active == 1'b0 && xfer_err == 1'b0, "R3 idle after crc",
              {tx_active, xfer_err}, 0);
    endtask

    // read n data bytes plus crc; flip selects one bit of the crc low byte to corrupt
    task automatic read_frame(input int n, input bit flip);
        logic [15:0] c;
        c = crc_of(n);
        frm[n]   = c[15:8];
        frm[n+1] = c[7:0] ^ (flip ? 8'h04 : 8'h00);
        go(1'b0);
        for (int j = 0; j < n + 2; j++) begin
            for (int b = 7; b >= 0; b--) rx_one(frm[j][b]);
            check(rd_ready == 1'b1 && rd_data == frm[j], "R5 rx byte",
                  {rd_ready, rd_data}, {1'b1, frm[j]});
            take();
        end
        pulse_last();
        check(crc_err == flip, "R7 crc result", crc_err, flip);
        check(xfer_err == 1'b0 && rd_ready == 1'b0, "R5 no overrun", {xfer_err, rd_ready}, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check({rd_ready, wr_ready, tx_active, tx_bit, crc_err, xfer_err} == 6'b0,
              "R1 reset outputs", {rd_ready, wr_ready, tx_active, tx_bit, crc_err, xfer_err}, 0);

        // R4 bits before any field are ignored
        for (int i = 0; i < 16; i++) rx_one(i[0]);
        check(rd_ready == 1'b0, "R4 no byte before go", rd_ready, 0);

        // R10 write buffer readiness
        go(1'b1);
        check(wr_ready == 1'b1, "R10 ready after write go", wr_ready, 1);
        @(negedge clk); wr_byte = 8'hA5; wr_load = 1'b1;
        @(negedge clk); wr_load = 1'b0;
        check(wr_ready == 1'b0, "R10 not ready when full", wr_ready, 0);
        go(1'b0);
        check(wr_ready == 1'b0, "R10 not ready in read mode", wr_ready, 0);
        pulse_last();

        // exhaustive single-byte write and read-back
        for (int v = 0; v < 256; v++) begin
            frm[0] = 8'(v);
            write_frame(1);
            frm[0] = 8'(v);
            read_frame(1, 1'b0);
        end

        // multi-byte frames
        for (int n = 2; n <= 4; n++) begin
            for (int s = 0; s < 4; s++) begin
                for (int i = 0; i < n; i++) frm[i] = 8'(i * 37 + s * 91 + n * 13 + 5);
                write_frame(n);
                for (int i = 0; i < n; i++) frm[i] = 8'(i * 37 + s * 91 + n * 13 + 5);
                read_frame(n, 1'b0);
            end
        end

        // R7 corrupted frame
        frm[0] = 8'h3C; frm[1] = 8'hC3; frm[2] = 8'h00;
        read_frame(3, 1'b1);
        // R9 field start clears errors
        go(1'b0);
        check(crc_err == 1'b0 && xfer_err == 1'b0, "R9 go clears flags", {crc_err, xfer_err}, 0);
        // R4 leftover pre-go bits do not disturb the CRC
        pulse_last();
        for (int i = 0; i < 5; i++) rx_one(1'b1);
        frm[0] = 8'h11; frm[1] = 8'h22;
        read_frame(2, 1'b0);

        // R6 double buffering and overrun
        go(1'b0);
        for (int b = 7; b >= 0; b--) rx_one(1'(8'h5A >> b));
        for (int b = 7; b >= 1; b--) rx_one(1'(8'hE1 >> b));
        check(rd_data == 8'h5A && rd_ready == 1'b1, "R6 held byte stable", rd_data, 8'h5A);
        take();
        rx_one(1'b1);
        check(rd_data == 8'hE1 && xfer_err == 1'b0, "R6 next byte no overrun", rd_data, 8'hE1);
        for (int b = 7; b >= 0; b--) rx_one(1'(8'h7E >> b));
        check(xfer_err == 1'b1 && rd_data == 8'h7E, "R6 overrun flagged", {xfer_err, rd_data}, {1'b1, 8'h7E});
        go(1'b0);
        check(xfer_err == 1'b0 && rd_ready == 1'b0, "R9 go clears overrun", {xfer_err, rd_ready}, 0);
        pulse_last();

        // R8 write underrun
        go(1'b1);
        rx_one(1'b0);
        check(xfer_err == 1'b1, "R8 underrun", xfer_err, 1);
        // R8 write overflow: three loads back to back
        go(1'b1);
        @(negedge clk); wr_byte = 8'h01; wr_load = 1'b1;
        @(negedge clk); wr_byte = 8'h02;
        check(xfer_err == 1'b0, "R8 two loads accepted", xfer_err, 0);
        @(negedge clk); wr_byte = 8'h03;
        @(negedge clk); wr_load = 1'b0;
        check(xfer_err == 1'b1, "R8 overflow", xfer_err, 1);
        go(1'b0);
        pulse_last();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule